// File: doc/BRIEF.md
# Banked DRAM Controller for an 8-bit CPU Bus

This block connects an 8-bit CPU bus (active-low memory request, I/O request, read, write, refresh strobe and opcode-fetch strobe) to a page-mode DRAM array built from 30-pin memory modules. It turns each CPU memory request into a multiplexed row/column access and turns each CPU refresh strobe into a CAS-before-RAS refresh. It asserts a wait line when an access has to hold off until the strobes are free.

The 64KB CPU space is split into two halves. The upper half (A15 = 1) always maps to one fixed physical page. The lower half maps to one of 256 pages of 32KB, chosen by an 8-bit page register. Software loads that register with a single I/O write to a fixed port. The 11 physical page-plus-offset bits above the row go out on the column cycle.

Top module: `zdram_bank_ctrl`

## Requirements
- R1: After reset, RAS, CAS, WE and WAIT are all high (inactive) and the page register holds 0.
- R2: An I/O cycle with IORQ low, WR low and M1 high whose address bits 7..0 equal 0x1F loads the page register from the 8-bit data bus.
- R3: I/O writes to any other port and memory writes do not change the page register. This is observed in the page bits of the next lower-half column address.
- R4: While RAS is low and CAS is high during an access, the DRAM address equals CPU A11..A0.
- R5: While CAS is low during an access, the DRAM address is {0, page[7:0], A14..A12}. Bits 2..0 carry A14..A12, bits 10..3 carry the page and bit 11 is 0.
- R6: An access with A15 = 1 uses page 255 in the column bits, whatever the page register holds.
- R7: RAS goes low on the first clock edge that samples MREQ low with RFSH high. CAS goes low one edge later, and both stay low until MREQ is sampled high.
- R8: WE is low during an access only while WR is low and RD is high. It stays high on reads and on refresh.
- R9: A clock edge that samples MREQ and RFSH both low starts a refresh. CAS goes low first, RAS joins it one edge later, and both go high on the following edge.
- R10: A refresh strobe that is held low over many clocks yields exactly one refresh cycle. A new one needs RFSH to be sampled high first.
- R11: After any access or refresh, RAS and CAS stay high for at least one full clock before either falls again.
- R12: WAIT is low while MREQ is low with RFSH high and a refresh or the precharge clock is in progress. The held access then starts once WAIT has gone high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus, used for page register loads |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| wait_n | output | 1 | Wait request to the CPU, active low |

## Verification
The hardest situation to reach is a memory request that arrives while a refresh is still running. A real CPU bus never produces it on its own. The bench starts a refresh and, one clock later, raises the refresh strobe while holding the memory request low. It then follows WAIT through the refresh and the precharge clock and confirms that the held access starts with the row address once WAIT goes high. A second hard case is a refresh strobe held low for many clocks, which must not repeat the refresh.

// File: rtl/zdram_pkg.sv
package zdram_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ROW     = 3'd1,
      ST_COL     = 3'd2,
      ST_REF_CAS = 3'd3,
      ST_REF_RAS = 3'd4,
      ST_PRECH   = 3'd5
   } seq_state_t;
endpackage

// File: rtl/zdram_page_reg.sv
module zdram_page_reg #(
   parameter int PAGE_W = 8,
   parameter int PORT_W = 8,
   parameter logic [PORT_W-1:0] PORT_ADDR = 8'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] port_addr,
   input  logic [PAGE_W-1:0] data_in,
   input  logic              iorq_n,
   input  logic              wr_n,
   input  logic              m1_n,
   output logic [PAGE_W-1:0] page_q
);
   logic hit;
   assign hit = !iorq_n && !wr_n && m1_n && (port_addr == PORT_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   page_q <= '0;
      else if (hit) page_q <= data_in;
   end

   // R3
   other_port_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iorq_n || wr_n || (port_addr != PORT_ADDR)) |=> $stable(page_q));
endmodule

// File: rtl/zdram_addr_mux.sv
module zdram_addr_mux #(
   parameter int CPU_AW  = 16,
   parameter int PAGE_W  = 8,
   parameter int DRAM_AW = 12
) (
   input  logic [CPU_AW-1:0]  cpu_addr,
   input  logic [PAGE_W-1:0]  page_q,
   input  logic               col_sel,
   output logic [DRAM_AW-1:0] dram_addr
);
   localparam int OFF_W   = CPU_AW - 1;
   localparam int HI_W    = OFF_W - DRAM_AW;
   localparam int COL_W   = HI_W + PAGE_W;
   localparam logic [PAGE_W-1:0] COMMON_PAGE = '1;

   logic [PAGE_W-1:0]  eff_page;
   logic [COL_W-1:0]   col_core;
   logic [DRAM_AW-1:0] col_addr;
   logic [DRAM_AW-1:0] row_addr;

   assign eff_page = cpu_addr[CPU_AW-1] ? COMMON_PAGE : page_q;
   assign col_core = {eff_page, cpu_addr[OFF_W-1:DRAM_AW]};
   assign row_addr = cpu_addr[DRAM_AW-1:0];

   generate
      if (HI_W < 1) begin : g_bad_split
         $error("row width leaves no offset bits for the column");
      end
      if (COL_W > DRAM_AW) begin : g_bad_col
         $error("column bits exceed the DRAM address width");
      end else if (COL_W == DRAM_AW) begin : g_col_full
         assign col_addr = col_core;
      end else begin : g_col_pad
         assign col_addr = {{(DRAM_AW-COL_W){1'b0}}, col_core};
      end
   endgenerate

   assign dram_addr = col_sel ? col_addr : row_addr;
endmodule

// File: rtl/zdram_seq.sv
module zdram_seq
   import zdram_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic mreq_n,
   input  logic rfsh_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic col_sel,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic wait_n
);
   seq_state_t st, st_nx;
   logic ref_armed;
   logic acc_req;

   assign acc_req = !mreq_n && rfsh_n;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: begin
            if (acc_req)                              st_nx = ST_ROW;
            else if (!mreq_n && !rfsh_n && ref_armed) st_nx = ST_REF_CAS;
         end
         ST_ROW:     st_nx = mreq_n ? ST_PRECH : ST_COL;
         ST_COL:     if (mreq_n) st_nx = ST_PRECH;
         ST_REF_CAS: st_nx = ST_REF_RAS;
         ST_REF_RAS: st_nx = ST_PRECH;
         ST_PRECH:   st_nx = ST_IDLE;
         default:    st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ref_armed <= 1'b1;
      end else begin
         st <= st_nx;
         if (st_nx == ST_REF_CAS) ref_armed <= 1'b0;
         else if (rfsh_n)         ref_armed <= 1'b1;
      end
   end

   assign ras_n   = !(st == ST_ROW || st == ST_COL || st == ST_REF_RAS);
   assign cas_n   = !(st == ST_COL || st == ST_REF_CAS || st == ST_REF_RAS);
   assign col_sel = (st == ST_COL);
   assign we_n    = !((st == ST_ROW || st == ST_COL) && !wr_n && rd_n);
   assign wait_n  = !(acc_req &&
                      (st == ST_REF_CAS || st == ST_REF_RAS || st == ST_PRECH));

   // R9
   cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !cas_n) |-> $past(!cas_n));
   // R7
   ras_before_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !ras_n) |-> $past(!ras_n));
   // R11
   precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (cas_n ##1 (ras_n && cas_n)));
   // R8
   we_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!ras_n && rfsh_n));
   // R12
   wait_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wait_n |-> (!mreq_n && ras_n == cas_n || !mreq_n));
endmodule

// File: rtl/zdram_bank_ctrl.sv
module zdram_bank_ctrl #(
   parameter int CPU_AW  = 16,
   parameter int PAGE_W  = 8,
   parameter int DRAM_AW = 12,
   parameter int PORT_W  = 8,
   parameter logic [PORT_W-1:0] PORT_ADDR = 8'h1F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CPU_AW-1:0]  cpu_addr,
   input  logic [PAGE_W-1:0]  cpu_data,
   input  logic               mreq_n,
   input  logic               iorq_n,
   input  logic               rd_n,
   input  logic               wr_n,
   input  logic               rfsh_n,
   input  logic               m1_n,
   output logic [DRAM_AW-1:0] dram_addr,
   output logic               dram_ras_n,
   output logic               dram_cas_n,
   output logic               dram_we_n,
   output logic               wait_n
);
   generate
      if (PORT_W > CPU_AW) begin : g_bad_port
         $error("port decode wider than CPU address");
      end
   endgenerate

   logic [PAGE_W-1:0] page_q;
   logic              col_sel;

   zdram_page_reg #(.PAGE_W(PAGE_W), .PORT_W(PORT_W), .PORT_ADDR(PORT_ADDR)) u_page (
      .clk(clk), .rst_n(rst_n), .port_addr(cpu_addr[PORT_W-1:0]),
      .data_in(cpu_data), .iorq_n(iorq_n), .wr_n(wr_n), .m1_n(m1_n),
      .page_q(page_q)
   );

   zdram_addr_mux #(.CPU_AW(CPU_AW), .PAGE_W(PAGE_W), .DRAM_AW(DRAM_AW)) u_mux (
      .cpu_addr(cpu_addr), .page_q(page_q), .col_sel(col_sel),
      .dram_addr(dram_addr)
   );

   zdram_seq u_seq (
      .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .rfsh_n(rfsh_n),
      .rd_n(rd_n), .wr_n(wr_n), .col_sel(col_sel), .ras_n(dram_ras_n),
      .cas_n(dram_cas_n), .we_n(dram_we_n), .wait_n(wait_n)
   );

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (dram_ras_n && dram_cas_n && wait_n));
endmodule

// File: tb/tb_zdram_bank_ctrl.sv
`timescale 1ns/1ps
module tb_zdram_bank_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        mreq_n = 1, iorq_n = 1, rd_n = 1, wr_n = 1, rfsh_n = 1, m1_n = 1;
   logic [11:0] dram_addr;
   logic        dram_ras_n, dram_cas_n, dram_we_n, wait_n;

   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   zdram_bank_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
      .rfsh_n(rfsh_n), .m1_n(m1_n), .dram_addr(dram_addr),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
      .dram_we_n(dram_we_n), .wait_n(wait_n)
   );

   task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic nxt();
      @(negedge clk); #1;
   endtask

   function automatic logic [11:0] col_of(input logic [15:0] a, input logic [7:0] pg);
      return {1'b0, (a[15] ? 8'hFF : pg), a[14:12]};
   endfunction

   task automatic io_write(input logic [7:0] port, input logic [7:0] d,
                           input logic io);
      @(negedge clk);
      cpu_addr = {8'h00, port}; cpu_data = d;
      if (io) iorq_n = 0; else mreq_n = 0;
      wr_n = 0;
      @(negedge clk);
      iorq_n = 1; wr_n = 1; mreq_n = 1;
      nxt(); nxt(); nxt();
   endtask

   // full access; checks row, column, strobes, WE and precharge
   task automatic mem_access(input logic [15:0] a, input bit wr,
                             input logic [7:0] pg, input string tag);
      @(negedge clk);
      cpu_addr = a; mreq_n = 0;
      if (wr) wr_n = 0; else rd_n = 0;
      #1;
      chk(dram_ras_n, {tag, " R7 RAS not early"}, {15'd0, dram_ras_n}, 16'd1);
      nxt();
      chk(!dram_ras_n && dram_cas_n, {tag, " R7 row phase"},
          {14'd0, dram_ras_n, dram_cas_n}, 16'd1);
      chk(dram_addr == a[11:0], {tag, " R4 row addr"}, {4'd0, dram_addr}, {4'd0, a[11:0]});
      chk(dram_we_n == !wr, {tag, " R8 WE row"}, {15'd0, dram_we_n}, {15'd0, !wr});
      nxt();
      chk(!dram_ras_n && !dram_cas_n, {tag, " R7 col phase"},
          {14'd0, dram_ras_n, dram_cas_n}, 16'd0);
      chk(dram_addr == col_of(a, pg), {tag, " R5 R6 col addr"},
          {4'd0, dram_addr}, {4'd0, col_of(a, pg)});
      chk(dram_we_n == !wr, {tag, " R8 WE col"}, {15'd0, dram_we_n}, {15'd0, !wr});
      mreq_n = 1; rd_n = 1; wr_n = 1;
      nxt();
      chk(dram_ras_n && dram_cas_n, {tag, " R11 precharge"},
          {14'd0, dram_ras_n, dram_cas_n}, 16'd3);
      nxt();
   endtask

   task automatic t_reset();
      chk(dram_ras_n && dram_cas_n && dram_we_n && wait_n, "R1 idle outputs",
          {12'd0, dram_ras_n, dram_cas_n, dram_we_n, wait_n}, 16'hF);
      mem_access(16'h1234, 0, 8'h00, "R1 page zero");
   endtask

   task automatic t_page_load();
      io_write(8'h1F, 8'hA5, 1);
      mem_access(16'h7ABC, 0, 8'hA5, "R2 load A5");
      io_write(8'h1F, 8'h3C, 1);
      mem_access(16'h0FFF, 1, 8'h3C, "R2 load 3C write");
   endtask

   task automatic t_ignore();
      io_write(8'h1E, 8'h11, 1);
      io_write(8'h9F, 8'h22, 1);
      io_write(8'h1F, 8'h33, 0);
      mem_access(16'h5555, 0, 8'h3C, "R3 ignored writes");
   endtask

   task automatic t_common();
      mem_access(16'h8001, 0, 8'h3C, "R6 common low");
      mem_access(16'hF123, 1, 8'h3C, "R6 common high");
   endtask

   task automatic t_refresh();
      @(negedge clk);
      cpu_addr = 16'h007F; mreq_n = 0; rfsh_n = 0; #1;
      chk(dram_cas_n && dram_ras_n, "R9 not early", {14'd0, dram_ras_n, dram_cas_n}, 16'd3);
      nxt();
      chk(!dram_cas_n && dram_ras_n, "R9 CAS first", {14'd0, dram_ras_n, dram_cas_n}, 16'd2);
      chk(dram_we_n, "R8 no WE in refresh", {15'd0, dram_we_n}, 16'd1);
      nxt();
      chk(!dram_cas_n && !dram_ras_n, "R9 RAS joins", {14'd0, dram_ras_n, dram_cas_n}, 16'd0);
      nxt();
      chk(dram_cas_n && dram_ras_n, "R9 release", {14'd0, dram_ras_n, dram_cas_n}, 16'd3);
      // R10: strobe held low longer must not repeat
      for (int i = 0; i < 6; i++) begin
         nxt();
         chk(dram_cas_n && dram_ras_n, "R10 single refresh",
             {14'd0, dram_ras_n, dram_cas_n}, 16'd3);
      end
      mreq_n = 1; rfsh_n = 1;
      nxt();
   endtask

   task automatic t_wait();
      @(negedge clk);
      cpu_addr = 16'h0042; mreq_n = 0; rfsh_n = 0;
      nxt();
      rfsh_n = 1; cpu_addr = 16'h2345; rd_n = 0; #1;
      chk(!wait_n, "R12 wait in refresh CAS", {15'd0, wait_n}, 16'd0);
      nxt();
      chk(!wait_n, "R12 wait in refresh RAS", {15'd0, wait_n}, 16'd0);
      nxt();
      chk(!wait_n && dram_ras_n && dram_cas_n, "R12 R11 wait in precharge",
          {13'd0, wait_n, dram_ras_n, dram_cas_n}, 16'd3);
      nxt();
      chk(wait_n && dram_ras_n, "R12 wait released",
          {14'd0, wait_n, dram_ras_n}, 16'd3);
      nxt();
      chk(!dram_ras_n && dram_cas_n && dram_addr == 12'h345, "R12 held access starts",
          {4'd0, dram_addr}, 16'h0345);
      mreq_n = 1; rd_n = 1;
      nxt(); nxt();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      nxt();
      t_reset();
      t_page_load();
      t_ignore();
      t_common();
      t_refresh();
      t_wait();
      mem_access(16'h6EDC, 1, 8'h3C, "R7 R8 after refresh");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule